// File: doc/BRIEF.md
# Debounced edge event counter

This block counts edges on one slow external input into a wide event counter. It is meant for signals from mechanical switches and contacts, which bounce. After each counted edge the edge detector is blocked for a programmable lockout. Any further edges of the counted polarity during that window are discarded, so contact bounce does not inflate the count.

The input is asynchronous. It passes through a two-stage synchronizer and an edge-compare register before it can be counted. The lockout is counted in coarse ticks from a free-running prescaler, nominally one tick per 16 ms. A lockout of L ticks therefore lasts between L and L+1 tick periods, depending on where the counted edge falls relative to the tick.

A single 16-bit configuration word holds both the lockout length and the edge polarity. Writing the all-zero word clears the counter. Software reads the count through a read strobe. The strobe captures the count as it stood in that cycle, so a read issued together with a clearing write still returns the count from before the clear.

Top module: `debounced_edge_counter`

## Requirements
- R1: After reset the count reads 0, the configuration is zero (falling edges, lockout 0), the detector is armed, and the level held on the pin during reset is never counted as an edge.
- R2: With configuration bit 8 clear, each falling edge of the pin is counted and rising edges are ignored.
- R3: With configuration bit 8 set, each rising edge of the pin is counted and falling edges are ignored.
- R4: Each accepted edge adds exactly one to the count. A pin change driven before a clock edge is reflected in the count at the third following clock edge.
- R5: With lockout L in configuration bits 7:0 and T clock cycles per tick, an edge of the counted polarity that arrives at most L*T-1 cycles after a counted edge is ignored. One that arrives at least (L+1)*T+3 cycles after it is counted.
- R6: Configuration word 0x0001 counts falling edges with a one-to-two tick lockout: an edge T-8 cycles after a counted edge is ignored and one 2*T+3 cycles after it is counted.
- R7: Writing the all-zero configuration word sets the count to 0, selects falling edges with lockout 0 and ends any running lockout. Reads return 0 until the next accepted edge, and an edge accepted in the same cycle as the clearing write is not counted.
- R8: A read strobe captures the count as it was before that cycle's update, and the value appears on the read port in the next cycle. A read issued in the same cycle as a clearing write returns the count from before the clear.
- R9: A nonzero configuration write keeps the count and applies the new polarity and lockout to later edges. A lockout that is already running is not shortened.
- R10: The count wraps from its all-ones value to 0 with no other effect.
- R11: With lockout 0 the detector re-arms within one tick, so an edge T+3 cycles after a counted edge is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pinAsync | input | 1 | Asynchronous external event input |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration word: bits 7:0 lockout ticks, bit 8 polarity (1 = rising); all-zero clears the count |
| cntRdEn | input | 1 | Count read strobe |
| cntRdData | output | CNT_W | Count captured by the previous read strobe |

## Verification
The assertions check, on every cycle, the relations between the control strobes and state. The count steps by exactly one on an accepted edge, holds otherwise and drops to zero on a clearing write. No edge is accepted while the lockout counter is busy. The lockout counter moves only on a tick. The read register returns the pre-update count. Only the bench scenarios can show the parts that depend on the pin and on real time. These are which polarity is counted, the three-cycle path from pin to count, the lower and upper bounds of the lockout for several lengths, the directed 0x0001 setting, wrap-around on a narrow instance, and reads racing a clearing write.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int CFG_W   = 16;
  localparam int LOCK_W  = 8;
  localparam int POL_BIT = 8;

  typedef struct packed {
    logic incCount;
    logic clrCount;
  } dpStrb_t;

  function automatic logic isClearWord(input logic [CFG_W-1:0] word);
    return word == '0;
  endfunction
endpackage

// File: rtl/bec_tick_gen.sv
module bec_tick_gen #(
  parameter int TICK_CYCLES = 800_000
) (
  input  logic clk,
  input  logic rst,
  output logic tickStb
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst)                 divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else                     divCnt <= divCnt + CW'(1);
  end

  assign tickStb = (divCnt == LAST);

  // tick is a single-cycle strobe, which the lockout timing relies on
  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    tickStb |=> !tickStb);
endmodule

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pinAsync,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             tickStb,
  output dpStrb_t          strb
);
  localparam int LC_W = LOCK_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES:0]   fillQ;
  logic                   prevQ;
  logic                   sampleNow;
  logic                   samplesValid;
  logic                   riseSeen;
  logic                   fallSeen;

  logic                   polQ;
  logic [LOCK_W-1:0]      lockLenQ;
  logic [LC_W-1:0]        lockCntQ;
  logic                   armed;
  logic                   clrWrite;
  logic                   accept;

  // input synchronizer plus one compare stage; fillQ masks reset-time levels
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      prevQ <= 1'b0;
      fillQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinAsync};
      prevQ <= syncQ[SYNC_STAGES-1];
      fillQ <= {fillQ[SYNC_STAGES-1:0], 1'b1};
    end
  end

  assign sampleNow    = syncQ[SYNC_STAGES-1];
  assign samplesValid = fillQ[SYNC_STAGES];
  assign riseSeen     = samplesValid &&  sampleNow && !prevQ;
  assign fallSeen     = samplesValid && !sampleNow &&  prevQ;

  assign clrWrite = cfgWrEn && isClearWord(cfgWrData);
  assign armed    = (lockCntQ == '0);
  assign accept   = armed && !clrWrite && (polQ ? riseSeen : fallSeen);

  always_ff @(posedge clk) begin
    if (rst) begin
      polQ     <= 1'b0;
      lockLenQ <= '0;
    end else if (cfgWrEn) begin
      polQ     <= cfgWrData[POL_BIT];
      lockLenQ <= cfgWrData[LOCK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   lockCntQ <= '0;
    else if (clrWrite)         lockCntQ <= '0;
    else if (accept)           lockCntQ <= {1'b0, lockLenQ} + LC_W'(1);
    else if (tickStb && !armed) lockCntQ <= lockCntQ - LC_W'(1);
  end

  always_comb begin
    strb.incCount = accept;
    strb.clrCount = clrWrite;
  end

  // no edge may be taken while the lockout is running
  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (lockCntQ != '0) |-> !strb.incCount);

  // a counted edge always starts a nonzero lockout
  p_lock_starts_r5: assert property (@(posedge clk) disable iff (rst)
    strb.incCount |=> (lockCntQ != '0));

  // the lockout only advances by one per tick
  p_lock_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (lockCntQ != '0) && tickStb && !cfgWrEn |=> lockCntQ == $past(lockCntQ) - LC_W'(1));

  // without tick or write the lockout holds
  p_lock_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !tickStb && !strb.incCount && !strb.clrCount |=> $stable(lockCntQ));

  // a clearing write leaves the detector armed
  p_clear_arms_r7: assert property (@(posedge clk) disable iff (rst)
    strb.clrCount |=> (lockCntQ == '0));
endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrb_t          strb,
  input  logic             rdEn,
  output logic [CNT_W-1:0] rdData
);
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (rst)                countQ <= '0;
    else if (strb.clrCount) countQ <= '0;
    else if (strb.incCount) countQ <= countQ + CNT_W'(1);
  end

  // capture takes the value before this cycle's update
  always_ff @(posedge clk) begin
    if (rst)       rdDataQ <= '0;
    else if (rdEn) rdDataQ <= countQ;
  end

  assign rdData = rdDataQ;

  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    strb.incCount && !strb.clrCount |=> countQ == $past(countQ) + CNT_W'(1));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    strb.clrCount |=> countQ == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.incCount && !strb.clrCount |=> $stable(countQ));

  p_read_old_r8: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdDataQ == $past(countQ));

  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    strb.incCount && !strb.clrCount && (countQ == '1) |=> countQ == '0);
endmodule

// File: rtl/debounced_edge_counter.sv
module debounced_edge_counter
  import bec_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int TICK_CYCLES = 800_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pinAsync,
  input  logic             cfgWrEn,
  input  logic [15:0]      cfgWrData,
  input  logic             cntRdEn,
  output logic [CNT_W-1:0] cntRdData
);
  logic    tickStb;
  dpStrb_t strb;

  bec_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .tickStb (tickStb)
  );

  bec_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pinAsync  (pinAsync),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .tickStb   (tickStb),
    .strb      (strb)
  );

  bec_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .rdEn   (cntRdEn),
    .rdData (cntRdData)
  );
endmodule

// File: tb/debounced_edge_counter_tb.sv
`timescale 1ns/1ps
module debounced_edge_counter_tb;
  localparam int T = 20;
  localparam int W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdMain;
  logic [3:0]  rdWrap;

  int unsigned     nCmp = 0;
  int unsigned     nBad = 0;
  longint unsigned expCount = 0;
  logic            idleLvl = 1'b1;
  int              elapsed = 0;
  int              curL = 0;

  always #2.5 clk = ~clk;

  debounced_edge_counter #(.CNT_W(32), .TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst(rst), .pinAsync(pin), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cntRdEn(rdEn), .cntRdData(rdMain));

  debounced_edge_counter #(.CNT_W(4), .TICK_CYCLES(T)) u_wrap (
    .clk(clk), .rst(rst), .pinAsync(pin), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cntRdEn(rdEn), .cntRdData(rdWrap));

  function automatic longint unsigned wrapOf(longint unsigned v);
    return v % 16;
  endfunction
  function automatic int minCountGap(int l);
    return (l + 1) * T + 3;
  endfunction
  function automatic int maxIgnoreStart(int l);
    return l * T - 1;
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
    elapsed += n;
  endtask

  task automatic waitTo(int n);
    while (elapsed < n) waitCycles(1);
  endtask

  task automatic readAndCheck(string tag);
    rdEn = 1'b1;
    waitCycles(1);
    rdEn = 1'b0;
    check(tag, longint'(rdMain), expCount);
    check({tag, " narrow"}, longint'(rdWrap), wrapOf(expCount));
  endtask

  task automatic writeCfg(logic [15:0] w);
    cfgWrEn = 1'b1;
    cfgWrData = w;
    waitCycles(1);
    cfgWrEn = 1'b0;
    if (w == 16'h0) begin
      expCount = 0;
      curL = 0;
    end else begin
      curL = int'(w[7:0]);
    end
    idleLvl = ~w[8];
    pin = idleLvl;
  endtask

  task automatic sendPulse();
    pin = ~idleLvl;
    waitCycles(W);
    pin = idleLvl;
  endtask

  task automatic sendCounted();
    waitTo(minCountGap(curL));
    elapsed = 0;
    expCount++;
    sendPulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete (all R tags) actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2718);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    waitCycles(6);

    // R1: reset state, pin held high through reset not counted
    readAndCheck("R1 reset count");
    elapsed = 1000;

    // R6: configuration 0x0001, falling edges, one-to-two tick lockout
    writeCfg(16'h0001);
    sendCounted();
    waitTo(T - 8);
    sendPulse();
    readAndCheck("R6 edge inside lockout ignored");
    sendCounted();
    waitCycles(3);
    readAndCheck("R6 edge after lockout counted");

    // R2: falling polarity ignores rising edges
    waitTo(minCountGap(curL));
    elapsed = 0; expCount++; pin = 1'b0;
    waitTo(minCountGap(curL));
    pin = 1'b1;
    waitCycles(minCountGap(curL));
    readAndCheck("R2 falling counted rising ignored");

    // R3: rising polarity ignores falling edges
    writeCfg(16'h0101);
    waitCycles(minCountGap(curL));
    elapsed = 0; expCount++; pin = 1'b1;
    waitTo(minCountGap(curL));
    pin = 1'b0;
    waitCycles(minCountGap(curL));
    readAndCheck("R3 rising counted falling ignored");

    // R9: nonzero write keeps the count
    writeCfg(16'h0103);
    waitCycles(2);
    readAndCheck("R9 count kept over reconfig");

    // R8: clearing write and read in the same cycle
    waitCycles(minCountGap(3));
    cfgWrEn = 1'b1; cfgWrData = 16'h0000; rdEn = 1'b1;
    waitCycles(1);
    cfgWrEn = 1'b0; rdEn = 1'b0;
    check("R8 read with clear returns old", longint'(rdMain), expCount);
    expCount = 0; curL = 0; idleLvl = 1'b1; pin = 1'b1;

    // R7: zero after clear until next edge
    readAndCheck("R7 count after clear");
    waitCycles(50);
    readAndCheck("R7 still zero");

    // R4: three-cycle path from pin to count, plus one step
    pin = 1'b0;
    waitCycles(2);
    rdEn = 1'b1;
    waitCycles(1);
    check("R4 before third edge", longint'(rdMain), expCount);
    waitCycles(1);
    rdEn = 1'b0;
    expCount++;
    check("R4 after third edge", longint'(rdMain), expCount);
    elapsed = 4;
    pin = 1'b1;
    waitCycles(5);
    readAndCheck("R7 counts again after clear");

    // R10 and R11: lockout zero, rising edges, narrow instance wraps
    writeCfg(16'h0100);
    for (int i = 0; i < 20; i++) sendCounted();
    waitCycles(minCountGap(0));
    readAndCheck("R11 lockout zero rearms");
    check("R10 narrow wrap", longint'(rdWrap), wrapOf(expCount));

    // R5: random configurations and pulse trains
    for (int r = 0; r < 25; r++) begin
      int l;
      int pol;
      int nP;
      l   = int'($urandom % 4);
      pol = int'($urandom % 2);
      if (l == 0 && pol == 0) l = 2;
      waitTo(minCountGap(curL));
      writeCfg({7'd0, pol[0], l[7:0]});
      waitCycles(3);
      elapsed = 1000;
      nP = 3 + int'($urandom % 5);
      for (int p = 0; p < nP; p++) begin
        if (p != 0 && l != 0 && ($urandom % 2) == 1 &&
            elapsed + 2 <= maxIgnoreStart(l)) begin
          waitCycles(2 + int'($urandom % (maxIgnoreStart(l) - elapsed - 1)));
          sendPulse();
        end else begin
          waitCycles(int'($urandom % 5));
          sendCounted();
        end
      end
      waitTo(minCountGap(curL));
      readAndCheck("R5 random lockout round");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule